// File: doc/BRIEF.md
# Single-cycle instruction control decoder

This block is the combinational control unit of a single-cycle RV32I datapath. It takes the 32-bit instruction word and the two flags from the branch comparator, equal and less-than. From these it drives every steering signal that the datapath needs: the next-PC source, the immediate format, the register-file write enable, the comparator signedness, the two ALU operand sources, the ALU operation, the data-memory direction and the write-back source.

Decoding looks only at opcode bits 6:2, the three funct3 bits and instruction bit 30. No other bit affects the result. The next-PC source for a conditional branch is computed in the same cycle from the decoded branch kind and the live comparator flags. Any encoding outside the supported set is treated as unrecognised and leaves architectural state untouched. A control output that does not matter for an instruction is driven to a fixed value.

Top module: `rv_ctl_decoder`

## Requirements
- R1: Register-register ops (opcode bits 6:2 = 01100) drive pc_sel=0 (PC+4), reg_wen=1, a_sel=0 (register), b_sel=0 (register), mem_wr=0 (read) and wb_sel=1 (ALU result).
- R2: For register-register ops, alu_sel is derived from funct3 (bits 14:12) and bit 30. The codes are ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8 and AND=9. Bit 30 selects SUB over ADD when funct3 is 000, and SRA over SRL when funct3 is 101.
- R3: addi (opcode 00100, funct3 000) drives imm_sel=0 (I), reg_wen=1, a_sel=0, b_sel=1 (immediate), alu_sel=ADD, mem_wr=0, wb_sel=1 and pc_sel=0.
- R4: lw (opcode 00000, funct3 010) matches addi except for wb_sel=0 (memory read data).
- R5: sw (opcode 01000, funct3 010) drives imm_sel=1 (S), reg_wen=0, a_sel=0, b_sel=1, alu_sel=ADD, mem_wr=1 and pc_sel=0.
- R6: Every supported branch (opcode 11000) drives imm_sel=2 (B), reg_wen=0, a_sel=1 (PC), b_sel=1, alu_sel=ADD and mem_wr=0.
- R7: beq (funct3 000) drives pc_sel=1 exactly when br_eq=1. bne (funct3 001) drives pc_sel=1 exactly when br_eq=0.
- R8: blt (funct3 100) drives br_un=0 and bltu (funct3 110) drives br_un=1. In both cases pc_sel=1 exactly when br_lt=1.
- R9: jal (opcode 11011) drives pc_sel=1, imm_sel=4 (J), reg_wen=1, a_sel=1, b_sel=1, alu_sel=ADD, mem_wr=0 and wb_sel=2 (PC+4).
- R10: jalr (opcode 11001, funct3 000) drives pc_sel=1, imm_sel=0, reg_wen=1, a_sel=0, b_sel=1, alu_sel=ADD, mem_wr=0 and wb_sel=2.
- R11: auipc (opcode 00101) drives pc_sel=0, imm_sel=3 (U), reg_wen=1, a_sel=1, b_sel=1, alu_sel=ADD, mem_wr=0 and wb_sel=1.
- R12: Instruction bits other than 30, 14:12 and 6:2 have no effect on any output.
- R13: Any unrecognised encoding, including the other funct3 values of the load, store, immediate, jalr and branch opcodes, drives reg_wen=0, mem_wr=0 and pc_sel=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inst | input | 32 | Instruction word being executed |
| br_eq | input | 1 | Comparator flag: operands equal |
| br_lt | input | 1 | Comparator flag: first operand less than second |
| pc_sel | output | 1 | Next PC source: 0 = PC+4, 1 = ALU result |
| imm_sel | output | 3 | Immediate format: 0 I, 1 S, 2 B, 3 U, 4 J |
| reg_wen | output | 1 | Register-file write enable |
| br_un | output | 1 | Comparator mode: 1 = unsigned |
| a_sel | output | 1 | ALU operand A: 0 = rs1 value, 1 = PC |
| b_sel | output | 1 | ALU operand B: 0 = rs2 value, 1 = immediate |
| alu_sel | output | ALU_SEL_W (4) | ALU operation code |
| mem_wr | output | 1 | Data memory direction: 1 = write |
| wb_sel | output | 2 | Write-back source: 0 memory, 1 ALU, 2 PC+4 |

## Verification
The bench builds the block with its default ALU code width of 4, which holds all ten operation codes. It sweeps every supported mnemonic and a set of unrecognised neighbours over all four comparator flag combinations. For each vector it fills the non-decoded instruction bits with fresh random values, so every check also tests that those bits have no effect. Fields that do not matter for a given instruction are masked out. The flag sweep exercises both outcomes of each conditional branch and confirms that the flags are ignored wherever they should not matter.

// File: rtl/rv_ctl_pkg.sv
package rv_ctl_pkg;

    localparam int INST_W = 32;

    // opcode bits 6:2 of the supported classes
    localparam logic [4:0] OPC_RR     = 5'b01100;
    localparam logic [4:0] OPC_IMM    = 5'b00100;
    localparam logic [4:0] OPC_LOAD   = 5'b00000;
    localparam logic [4:0] OPC_STORE  = 5'b01000;
    localparam logic [4:0] OPC_BRANCH = 5'b11000;
    localparam logic [4:0] OPC_JAL    = 5'b11011;
    localparam logic [4:0] OPC_JALR   = 5'b11001;
    localparam logic [4:0] OPC_AUIPC  = 5'b00101;

    typedef enum logic [3:0] {
        CLS_BAD, CLS_RR, CLS_ADDI, CLS_LOAD, CLS_STORE,
        CLS_BRANCH, CLS_JAL, CLS_JALR, CLS_AUIPC
    } op_class_e;

    typedef enum logic [1:0] {BRK_EQ, BRK_NE, BRK_LT, BRK_LTU} br_kind_e;

    typedef enum logic [2:0] {IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2,
                              IMM_U = 3'd3, IMM_J = 3'd4} imm_fmt_e;

    typedef enum logic [1:0] {WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2} wb_src_e;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
        ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
        ALU_OR = 4'd8, ALU_AND = 4'd9
    } alu_op_e;

    // the decoded fields of an instruction word
    typedef struct packed {
        logic [4:0] opc;
        logic [2:0] f3;
        logic       alt;
    } dec_fields_t;

    function automatic dec_fields_t pick_fields(input logic [INST_W-1:0] w);
        dec_fields_t f;
        f.opc = w[6:2];
        f.f3  = w[14:12];
        f.alt = w[30];
        return f;
    endfunction

endpackage

// File: rtl/rv_ctl_classify.sv
module rv_ctl_classify
    import rv_ctl_pkg::*;
(
    input  dec_fields_t fld,
    output op_class_e   cls,
    output br_kind_e    bkind
);
    always_comb begin
        cls   = CLS_BAD;
        bkind = BRK_EQ;
        unique case (fld.opc)
            OPC_RR:    cls = CLS_RR;
            OPC_IMM:   if (fld.f3 == 3'b000) cls = CLS_ADDI;
            OPC_LOAD:  if (fld.f3 == 3'b010) cls = CLS_LOAD;
            OPC_STORE: if (fld.f3 == 3'b010) cls = CLS_STORE;
            OPC_JAL:   cls = CLS_JAL;
            OPC_JALR:  if (fld.f3 == 3'b000) cls = CLS_JALR;
            OPC_AUIPC: cls = CLS_AUIPC;
            OPC_BRANCH: begin
                unique case (fld.f3)
                    3'b000: begin cls = CLS_BRANCH; bkind = BRK_EQ;  end
                    3'b001: begin cls = CLS_BRANCH; bkind = BRK_NE;  end
                    3'b100: begin cls = CLS_BRANCH; bkind = BRK_LT;  end
                    3'b110: begin cls = CLS_BRANCH; bkind = BRK_LTU; end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rv_ctl_next_pc.sv
module rv_ctl_next_pc
    import rv_ctl_pkg::*;
(
    input  op_class_e cls,
    input  br_kind_e  bkind,
    input  logic      eq_flag,
    input  logic      lt_flag,
    output logic      take_alu,
    output logic      unsigned_cmp
);
    logic cond_met;

    always_comb begin
        unique case (bkind)
            BRK_EQ:  cond_met = eq_flag;
            BRK_NE:  cond_met = !eq_flag;
            default: cond_met = lt_flag;
        endcase
    end

    always_comb begin
        unsigned_cmp = (cls == CLS_BRANCH) && (bkind == BRK_LTU);
        unique case (cls)
            CLS_JAL, CLS_JALR: take_alu = 1'b1;
            CLS_BRANCH:        take_alu = cond_met;
            default:           take_alu = 1'b0;
        endcase
    end
endmodule

// File: rtl/rv_ctl_alu_pick.sv
module rv_ctl_alu_pick
    import rv_ctl_pkg::*;
#(
    parameter int ALU_SEL_W = 4
) (
    input  op_class_e              cls,
    input  dec_fields_t            fld,
    output logic [ALU_SEL_W-1:0]   op
);
    localparam int CODE_W = $bits(alu_op_e);
    alu_op_e sel;

    always_comb begin
        sel = ALU_ADD;
        if (cls == CLS_RR) begin
            unique case (fld.f3)
                3'b000: sel = fld.alt ? ALU_SUB : ALU_ADD;
                3'b001: sel = ALU_SLL;
                3'b010: sel = ALU_SLT;
                3'b011: sel = ALU_SLTU;
                3'b100: sel = ALU_XOR;
                3'b101: sel = fld.alt ? ALU_SRA : ALU_SRL;
                3'b110: sel = ALU_OR;
                default: sel = ALU_AND;
            endcase
        end
    end

    generate
        if (ALU_SEL_W > CODE_W) begin : g_wide
            assign op = {{(ALU_SEL_W-CODE_W){1'b0}}, sel};
        end else begin : g_fit
            assign op = sel[ALU_SEL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rv_ctl_decoder.sv
module rv_ctl_decoder
    import rv_ctl_pkg::*;
#(
    parameter int ALU_SEL_W = 4
) (
    input  logic [31:0]          inst,
    input  logic                 br_eq,
    input  logic                 br_lt,
    output logic                 pc_sel,
    output logic [2:0]           imm_sel,
    output logic                 reg_wen,
    output logic                 br_un,
    output logic                 a_sel,
    output logic                 b_sel,
    output logic [ALU_SEL_W-1:0] alu_sel,
    output logic                 mem_wr,
    output logic [1:0]           wb_sel
);
    dec_fields_t fld;
    op_class_e   cls;
    br_kind_e    bkind;
    imm_fmt_e    imm_f;
    wb_src_e     wb_f;
    logic        unused_bits;

    assign fld         = pick_fields(inst);
    assign unused_bits = ^{inst[31], inst[29:15], inst[11:7], inst[1:0]};

    rv_ctl_classify u_classify (.fld(fld), .cls(cls), .bkind(bkind));

    rv_ctl_next_pc u_next_pc (
        .cls(cls), .bkind(bkind), .eq_flag(br_eq), .lt_flag(br_lt),
        .take_alu(pc_sel), .unsigned_cmp(br_un)
    );

    rv_ctl_alu_pick #(.ALU_SEL_W(ALU_SEL_W)) u_alu_pick (
        .cls(cls), .fld(fld), .op(alu_sel)
    );

    always_comb begin
        imm_f   = IMM_I;
        wb_f    = WB_ALU;
        reg_wen = 1'b0;
        a_sel   = 1'b0;
        b_sel   = 1'b1;
        mem_wr  = 1'b0;
        unique case (cls)
            CLS_RR:     begin reg_wen = 1'b1; b_sel = 1'b0; end
            CLS_ADDI:   reg_wen = 1'b1;
            CLS_LOAD:   begin reg_wen = 1'b1; wb_f = WB_MEM; end
            CLS_STORE:  begin imm_f = IMM_S; mem_wr = 1'b1; end
            CLS_BRANCH: begin imm_f = IMM_B; a_sel = 1'b1; end
            CLS_JAL:    begin imm_f = IMM_J; reg_wen = 1'b1; a_sel = 1'b1; wb_f = WB_PC4; end
            CLS_JALR:   begin reg_wen = 1'b1; wb_f = WB_PC4; end
            CLS_AUIPC:  begin imm_f = IMM_U; reg_wen = 1'b1; a_sel = 1'b1; end
            default:    b_sel = 1'b0;
        endcase
    end

    assign imm_sel = imm_f;
    assign wb_sel  = wb_f;

    // checks across the classifier, next-PC unit, ALU picker and signal table
    always_comb begin
        assert_bad_quiet_R13: assert (cls != CLS_BAD || (!reg_wen && !mem_wr && !pc_sel))
            else $error("unrecognised encoding changes state");
        assert_store_no_wen_R5: assert (!mem_wr || (!reg_wen && !pc_sel && alu_sel == ALU_SEL_W'(0)))
            else $error("store also writes register or redirects");
        assert_redirect_src_R7: assert (!pc_sel || wb_sel == 2'd2 || imm_sel == 3'd2)
            else $error("PC redirect outside jump or branch");
        assert_unsigned_only_branch_R8: assert (!br_un || (imm_sel == 3'd2 && !reg_wen))
            else $error("unsigned compare outside branch");
        assert_link_jumps_R9: assert (wb_sel != 2'd2 || (pc_sel && reg_wen))
            else $error("link write-back without jump");
    end
endmodule

// File: tb/rv_ctl_decoder_bench.sv
module rv_ctl_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NMNEM = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] inst = 32'h0;
    logic br_eq = 1'b0, br_lt = 1'b0;
    logic pc_sel, reg_wen, br_un, a_sel, b_sel, mem_wr;
    logic [2:0] imm_sel;
    logic [3:0] alu_sel;
    logic [1:0] wb_sel;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_ctl_decoder u_rv_ctl_decoder (
        .inst(inst), .br_eq(br_eq), .br_lt(br_lt), .pc_sel(pc_sel),
        .imm_sel(imm_sel), .reg_wen(reg_wen), .br_un(br_un), .a_sel(a_sel),
        .b_sel(b_sel), .alu_sel(alu_sel), .mem_wr(mem_wr), .wb_sel(wb_sel)
    );

    // expected vector; -1 marks a don't-care field
    int e_pc, e_imm, e_wen, e_un, e_a, e_b, e_alu, e_mw, e_wb;
    string e_req;
    logic [6:0] m_opc;
    logic [2:0] m_f3;
    logic       m_alt;

    task automatic model(input int id, input logic eq, input logic lt);
        e_pc = 0; e_imm = -1; e_wen = 0; e_un = -1; e_a = -1; e_b = -1;
        e_alu = -1; e_mw = 0; e_wb = -1; m_alt = 1'b0; m_f3 = 3'b000;
        if (id < 10) begin
            m_opc = 7'b0110011; e_req = "R1/R2";
            e_wen = 1; e_a = 0; e_b = 0; e_wb = 1;
            case (id)
                0: begin m_f3 = 0; e_alu = 0; end
                1: begin m_f3 = 0; m_alt = 1; e_alu = 1; end
                2: begin m_f3 = 1; e_alu = 2; end
                3: begin m_f3 = 2; e_alu = 3; end
                4: begin m_f3 = 3; e_alu = 4; end
                5: begin m_f3 = 4; e_alu = 5; end
                6: begin m_f3 = 5; e_alu = 6; end
                7: begin m_f3 = 5; m_alt = 1; e_alu = 7; end
                8: begin m_f3 = 6; e_alu = 8; end
                default: begin m_f3 = 7; e_alu = 9; end
            endcase
        end else begin
            case (id)
                10: begin m_opc = 7'b0010011; e_req = "R3"; e_imm = 0; e_wen = 1; e_a = 0; e_b = 1; e_alu = 0; e_wb = 1; end
                11: begin m_opc = 7'b0000011; m_f3 = 2; e_req = "R4"; e_imm = 0; e_wen = 1; e_a = 0; e_b = 1; e_alu = 0; e_wb = 0; end
                12: begin m_opc = 7'b0100011; m_f3 = 2; e_req = "R5"; e_imm = 1; e_a = 0; e_b = 1; e_alu = 0; e_mw = 1; end
                13: begin m_opc = 7'b1100011; m_f3 = 0; e_req = "R6/R7"; e_pc = eq ? 1 : 0; end
                14: begin m_opc = 7'b1100011; m_f3 = 1; e_req = "R6/R7"; e_pc = eq ? 0 : 1; end
                15: begin m_opc = 7'b1100011; m_f3 = 4; e_req = "R6/R8"; e_un = 0; e_pc = lt ? 1 : 0; end
                16: begin m_opc = 7'b1100011; m_f3 = 6; e_req = "R6/R8"; e_un = 1; e_pc = lt ? 1 : 0; end
                17: begin m_opc = 7'b1101111; e_req = "R9"; e_pc = 1; e_imm = 4; e_wen = 1; e_a = 1; e_b = 1; e_alu = 0; e_wb = 2; end
                18: begin m_opc = 7'b1100111; e_req = "R10"; e_pc = 1; e_imm = 0; e_wen = 1; e_a = 0; e_b = 1; e_alu = 0; e_wb = 2; end
                19: begin m_opc = 7'b0010111; e_req = "R11"; e_imm = 3; e_wen = 1; e_a = 1; e_b = 1; e_alu = 0; e_wb = 1; end
                20: begin m_opc = 7'b0110111; e_req = "R13"; end
                21: begin m_opc = 7'b0000011; m_f3 = 0; e_req = "R13"; end
                22: begin m_opc = 7'b1100011; m_f3 = 5; e_req = "R13"; end
                23: begin m_opc = 7'b0010011; m_f3 = 1; e_req = "R13"; end
                default: begin m_opc = 7'b1100111; m_f3 = 3; e_req = "R13"; end
            endcase
            if (id >= 13 && id <= 16) begin
                e_imm = 2; e_a = 1; e_b = 1; e_alu = 0;
            end
        end
    endtask

    function automatic bit fld_bad(input int exp, input int act);
        return (exp >= 0) && (exp != act);
    endfunction

    task automatic compare(input string tag);
        bit bad;
        n_run++;
        bad = fld_bad(e_pc, pc_sel) || fld_bad(e_imm, imm_sel) || fld_bad(e_wen, reg_wen) ||
              fld_bad(e_un, br_un) || fld_bad(e_a, a_sel) || fld_bad(e_b, b_sel) ||
              fld_bad(e_alu, alu_sel) || fld_bad(e_mw, mem_wr) || fld_bad(e_wb, wb_sel);
        if (bad) begin
            n_fail++;
            $display("FAIL %s (%s) inst=%h eq=%0b lt=%0b: got pc=%0d imm=%0d wen=%0d un=%0d a=%0d b=%0d alu=%0d mw=%0d wb=%0d; want pc=%0d imm=%0d wen=%0d un=%0d a=%0d b=%0d alu=%0d mw=%0d wb=%0d",
                     e_req, tag, inst, br_eq, br_lt, pc_sel, imm_sel, reg_wen, br_un, a_sel, b_sel,
                     alu_sel, mem_wr, wb_sel, e_pc, e_imm, e_wen, e_un, e_a, e_b, e_alu, e_mw, e_wb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // reset state: all-zero word is an unrecognised load width (R13)
        @(negedge clk);
        model(21, 1'b0, 1'b0);
        compare("reset R13");
        rst = 1'b0;
        for (int id = 0; id < NMNEM; id++) begin
            for (int fl = 0; fl < 4; fl++) begin
                for (int rep = 0; rep < 3; rep++) begin
                    @(posedge clk);
                    #1;
                    model(id, fl[0], fl[1]);
                    // random fill of non-decoded bits exercises R12
                    inst = $urandom;
                    inst[6:0] = m_opc;
                    inst[14:12] = m_f3;
                    inst[30] = m_alt;
                    br_eq = fl[0];
                    br_lt = fl[1];
                    @(negedge clk);
                    compare("sweep R12");
                end
            end
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, want completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule